// File: doc/BRIEF.md
# Decimal Up/Down Digit Counter

This block holds one decimal digit and steps it up or down by one on each enabled clock edge. A direction input picks the counting sense. A synchronous initialise input presets the digit to the value where a count in the chosen sense begins: 0 for upward counting and 9 for downward counting. In both directions the count stays inside the decimal range. An upward count past 9 returns to 0, and a downward count past 0 returns to 9.

A combinational terminal-count output goes high in the cycle before the digit wraps. A neighbouring digit can use it as its own enable, which lets several digits be cascaded outside this block. The wrap points are found with equality tests only. The radix is a parameter whose default is 10, and the digit width is derived from it.

Top module: `dec_digit_counter`

## Requirements
- R1: `rst` is synchronous and active high. It sets the digit to 0 at the next rising clock edge and overrides every other input.
- R2: With `rst` low and `init` high, the next edge loads 0 when `dir_up` is 1 and 9 when `dir_up` is 0, whatever the value of `en`.
- R3: With `rst` and `init` low, `en` high and `dir_up` at 1, a digit below 9 increases by one on the next edge.
- R4: With `rst` and `init` low, `en` high and `dir_up` at 1, a digit of 9 becomes 0 on the next edge.
- R5: With `rst` and `init` low, `en` high and `dir_up` at 0, a digit above 0 decreases by one on the next edge.
- R6: With `rst` and `init` low, `en` high and `dir_up` at 0, a digit of 0 becomes 9 on the next edge.
- R7: With `rst`, `init` and `en` all low, the digit keeps its value across the edge.
- R8: Once reset has been applied, the digit never leaves the range 0 to 9.
- R9: `carry` is combinational. It is 1 exactly when `en` is 1, `init` is 0, and either `dir_up` is 1 with the digit at 9 or `dir_up` is 0 with the digit at 0. It is 0 at all other times.
- R10: A change of `dir_up` takes effect in the same cycle, for counting, loading and `carry` alike.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset, clears the digit to 0 |
| dir_up | input | 1 | 1 counts up, 0 counts down |
| init | input | 1 | Synchronous preset: 0 when counting up, 9 when counting down |
| en | input | 1 | Count enable |
| digit | output | 4 | Registered decimal digit, 0 to 9 |
| carry | output | 1 | Terminal count: the next enabled step wraps the digit |

## Verification
The bound checker tests every cycle after reset against a one-cycle rule:
- the range bound;
- the preset values;
- increment, decrement and both wraps;
- the hold when idle;
- the digit that follows an asserted `carry`.

Some behaviours need chosen stimulus rather than a one-cycle rule. Reset overriding a simultaneous preset and count, and direction reversal in mid-sequence, are shown only by the bench's scenarios. So is the exact combinational timing of `carry` within a cycle. The bench covers these with a sweep over every start digit and every combination of direction, preset and enable.

// File: rtl/ddc_pkg.sv
`timescale 1ns/1ps
package ddc_pkg;
  typedef enum logic {
    DIR_DOWN = 1'b0,
    DIR_UP   = 1'b1
  } dir_e;

  typedef enum logic [1:0] {
    ACT_HOLD = 2'd0,
    ACT_LOAD = 2'd1,
    ACT_STEP = 2'd2
  } act_e;
endpackage

// File: rtl/ddc_terminal.sv
`timescale 1ns/1ps
// Flags the digit value at which the next step in the current sense wraps.
module ddc_terminal #(
  parameter int DW  = 4,
  parameter int TOP = 9
) (
  input  logic [DW-1:0] digit,
  input  logic          dir,
  output logic          at_term
);
  import ddc_pkg::*;
  localparam logic [DW-1:0] TOP_V = DW'(TOP);

  always_comb begin
    if (dir == DIR_UP) at_term = (digit == TOP_V);
    else               at_term = (digit == '0);
  end
endmodule

// File: rtl/ddc_next.sv
`timescale 1ns/1ps
// Next-value selection: preset, step with wrap, or hold.
module ddc_next #(
  parameter int DW  = 4,
  parameter int TOP = 9
) (
  input  logic [DW-1:0] digit,
  input  logic          dir,
  input  logic          init,
  input  logic          en,
  input  logic          at_term,
  output logic [DW-1:0] nxt
);
  import ddc_pkg::*;
  localparam logic [DW-1:0] TOP_V = DW'(TOP);

  act_e act;

  always_comb begin
    if (init)    act = ACT_LOAD;
    else if (en) act = ACT_STEP;
    else         act = ACT_HOLD;
  end

  always_comb begin
    nxt = digit;
    unique case (act)
      ACT_LOAD: nxt = (dir == DIR_UP) ? '0 : TOP_V;
      ACT_STEP: begin
        if (dir == DIR_UP) nxt = at_term ? '0 : DW'(digit + 1'b1);
        else               nxt = at_term ? TOP_V : DW'(digit - 1'b1);
      end
      default:  nxt = digit;
    endcase
  end
endmodule

// File: rtl/ddc_reg.sv
`timescale 1ns/1ps
// Digit storage with synchronous active-high clear.
module ddc_reg #(
  parameter int DW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] d,
  output logic [DW-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= d;
  end
endmodule

// File: rtl/dec_digit_counter.sv
`timescale 1ns/1ps
// Single-digit up/down counter in a configurable radix (decimal by default).
module dec_digit_counter #(
  parameter  int RADIX = 10,
  localparam int DW    = $clog2(RADIX)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          dir_up,
  input  logic          init,
  input  logic          en,
  output logic [DW-1:0] digit,
  output logic          carry
);
  localparam int TOP = RADIX - 1;

  logic          at_term;
  logic [DW-1:0] nxt;

  ddc_terminal #(.DW(DW), .TOP(TOP)) u_term (
    .digit   (digit),
    .dir     (dir_up),
    .at_term (at_term)
  );

  ddc_next #(.DW(DW), .TOP(TOP)) u_next (
    .digit   (digit),
    .dir     (dir_up),
    .init    (init),
    .en      (en),
    .at_term (at_term),
    .nxt     (nxt)
  );

  ddc_reg #(.DW(DW)) u_reg (
    .clk (clk),
    .rst (rst),
    .d   (nxt),
    .q   (digit)
  );

  assign carry = en & ~init & at_term;
endmodule

// File: rtl/ddc_checker.sv
`timescale 1ns/1ps
module ddc_checker #(
  parameter  int RADIX = 10,
  localparam int DW    = $clog2(RADIX)
) (
  input logic          clk,
  input logic          rst,
  input logic          dir_up,
  input logic          init,
  input logic          en,
  input logic [DW-1:0] digit,
  input logic          carry
);
  localparam logic [DW-1:0] TOP_V = DW'(RADIX - 1);

  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> digit == '0);

  assert_preset_R2: assert property (@(posedge clk) disable iff (rst)
    init |=> digit == ($past(dir_up) ? '0 : TOP_V));

  assert_count_up_R3: assert property (@(posedge clk) disable iff (rst)
    (!init && en && dir_up && digit != TOP_V) |=> digit == DW'($past(digit) + 1'b1));

  assert_wrap_up_R4: assert property (@(posedge clk) disable iff (rst)
    (!init && en && dir_up && digit == TOP_V) |=> digit == '0);

  assert_count_down_R5: assert property (@(posedge clk) disable iff (rst)
    (!init && en && !dir_up && digit != '0) |=> digit == DW'($past(digit) - 1'b1));

  assert_wrap_down_R6: assert property (@(posedge clk) disable iff (rst)
    (!init && en && !dir_up && digit == '0) |=> digit == TOP_V);

  assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (!init && !en) |=> $stable(digit));

  assert_in_range_R8: assert property (@(posedge clk) disable iff (rst)
    digit <= TOP_V);

  assert_carry_wraps_R9: assert property (@(posedge clk) disable iff (rst)
    carry |=> digit == ($past(dir_up) ? '0 : TOP_V));
endmodule

bind dec_digit_counter ddc_checker #(.RADIX(RADIX)) u_chk (
  .clk    (clk),
  .rst    (rst),
  .dir_up (dir_up),
  .init   (init),
  .en     (en),
  .digit  (digit),
  .carry  (carry)
);

// File: tb/sim_dec_digit_counter.sv
`timescale 1ns/1ps
module sim_dec_digit_counter;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       dir_up = 1'b0;
  logic       init = 1'b0;
  logic       en = 1'b0;
  logic [3:0] digit;
  logic       carry;

  int n_vec = 0;
  int n_bad = 0;
  int exp_d = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  dec_digit_counter #(.RADIX(10)) u0 (
    .clk    (clk),
    .rst    (rst),
    .dir_up (dir_up),
    .init   (init),
    .en     (en),
    .digit  (digit),
    .carry  (carry)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // One cycle: drive after a falling edge, check carry, clock, then check digit.
  task automatic step(input logic r, input logic d, input logic i, input logic e);
    string tag;
    int    term;
    @(negedge clk);
    rst = r; dir_up = d; init = i; en = e;
    #1;
    term = (d && exp_d == 9) || (!d && exp_d == 0);
    chk(d ? "R9 carry (R10 up)" : "R9 carry (R10 down)", int'(carry),
        (e && !i && term) ? 1 : 0);
    if (r)       begin tag = "R1 reset";      exp_d = 0; end
    else if (i)  begin tag = "R2 preset";     exp_d = d ? 0 : 9; end
    else if (!e) begin tag = "R7 hold"; end
    else if (d)  begin
      if (exp_d == 9) begin tag = "R4 wrap up"; exp_d = 0; end
      else            begin tag = "R3 count up"; exp_d = exp_d + 1; end
    end else begin
      if (exp_d == 0) begin tag = "R6 wrap down"; exp_d = 9; end
      else            begin tag = "R5 count down"; exp_d = exp_d - 1; end
    end
    @(posedge clk);
    #1;
    chk(tag, int'(digit), exp_d);
    chk("R8 range", int'(digit <= 4'd9), 1);
  endtask

  initial begin
    // reset state
    step(1'b1, 1'b0, 1'b0, 1'b0);
    step(1'b1, 1'b1, 1'b1, 1'b1);
    // every start digit x every direction/preset/enable combination
    for (int s = 0; s < 10; s++) begin
      for (int c = 0; c < 8; c++) begin
        step(1'b1, 1'b0, 1'b0, 1'b0);
        for (int k = 0; k < s; k++) step(1'b0, 1'b1, 1'b0, 1'b1);
        step(1'b0, c[2], c[1], c[0]);
      end
    end
    // long runs through several wraps
    step(1'b0, 1'b1, 1'b1, 1'b0);
    for (int k = 0; k < 23; k++) step(1'b0, 1'b1, 1'b0, 1'b1);
    step(1'b0, 1'b0, 1'b1, 1'b1);
    for (int k = 0; k < 23; k++) step(1'b0, 1'b0, 1'b0, 1'b1);
    // R10: direction reversals mid-sequence, with idle cycles mixed in
    for (int k = 0; k < 30; k++) step(1'b0, (k % 3) != 0, 1'b0, (k % 5) != 4);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule